// File: doc/BRIEF.md
# Inter-Subarray Row Copy Sequencer

This block sits in front of one DRAM bank and turns a request into a timed command stream for that bank. For a copy request, it moves a whole row from one subarray to another. It does not read and write the row piece by piece through the narrow bank data path. Instead, it opens the source row and then walks the latched row buffer contents across the isolation links between neighbouring subarrays, one hop at a time. Each subarray is closed once the data has left it. The destination row is then activated, which writes the arriving buffer contents into that row, and the destination is closed. When no copy is pending, the same sequencer serves a plain single-row open/close request.

A request is a one-cycle `req_valid` strobe that carries a copy/single flag and a source and destination (subarray, row) pair. The block accepts it only while idle. It raises `busy` until the last precharge has had its full recovery time. It then pulses `done` for one cycle, and `err` as well when the copy was refused. The timing gaps between commands are parameters counted in controller clock cycles: activate-to-next (`T_RCD`), hop duration (`T_RBM`) and precharge recovery (`T_RP`), with defaults of 6, 4 and 6.

Top module: `rowcopy_seq`

## Requirements
- R1: While reset is held and whenever the block is idle, `busy`, `done` and `err` are 0 and `cmd_op` is NOP (encoding 0).
- R2: A single-row request (`req_copy`=0) accepted at edge E drives ACT (code 1) on the source subarray and row in the cycle after E. PRE (code 2) on that subarray follows `T_RCD` cycles later, and `done` follows the PRE by `T_RP` cycles.
- R3: A copy request between distinct subarrays drives ACT of the source row in the cycle after acceptance. The first row-buffer move (code 3) follows `T_RCD` cycles later, and the source row's contents end up written into the destination row.
- R4: Each move names the current subarray in `cmd_sub` and an adjacent subarray in `cmd_tgt`, one step nearer the destination. PRE of the current subarray follows `T_RBM` cycles after the move. The next move, if any, follows that PRE by one cycle, so a copy spanning k subarrays issues exactly k moves, each into a closed subarray.
- R5: One cycle after the PRE that closes the last hop, ACT is driven on the destination subarray with the destination row. PRE of the destination follows `T_RCD` cycles later.
- R6: `done` is a one-cycle pulse `T_RP` cycles after the final PRE. `busy` is 1 from the cycle after acceptance through the `done` cycle, and 0 in the cycle after it.
- R7: A copy whose source and destination subarrays are equal issues no command. It pulses `done` and `err` together in the cycle after acceptance.
- R8: A request presented while `busy` is 1, including in the `done` cycle, is ignored: it adds no command and no written row.
- R9: When the destination subarray index is lower than the source index, the moves step downward through every intermediate subarray.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | One-cycle request strobe, taken only while idle |
| req_copy | input | 1 | 1 = inter-subarray copy, 0 = single-row open/close |
| req_src_sub | input | $clog2(N_SUB) | Source subarray index |
| req_src_row | input | $clog2(ROWS_PER_SUB) | Source row inside its subarray |
| req_dst_sub | input | $clog2(N_SUB) | Destination subarray index (copy only) |
| req_dst_row | input | $clog2(ROWS_PER_SUB) | Destination row (copy only) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With `done`: copy refused (same subarray) |
| cmd_op | output | 2 | 0 NOP, 1 ACT, 2 PRE, 3 row-buffer move |
| cmd_sub | output | $clog2(N_SUB) | Subarray addressed; move source for code 3 |
| cmd_tgt | output | $clog2(N_SUB) | Move target subarray (code 3 only) |
| cmd_row | output | $clog2(ROWS_PER_SUB) | Row for ACT |

## Verification
The assertions assume that every subarray of the bank is precharged whenever the block is idle, so that a hop target is always closed. They also assume that the timing parameters are each at least 2, and that subarray indices stay below `N_SUB`. The stimulus respects these limits by construction. It leaves the bank closed at the end of each request, it uses only indices 0 to 7 with the default parameters, and it drives requests one cycle wide at the falling edge. It deliberately places extra strobes inside busy windows, including the completion cycle. A behavioural bank model in the bench separately confirms that no move lands on an open subarray.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_PRE = 2'd2,
    OP_RBM = 2'd3
  } rcs_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACT_SRC,
    ST_W_ACT_SRC,
    ST_MOVE,
    ST_W_MOVE,
    ST_PRE_HOP,
    ST_ACT_DST,
    ST_W_ACT_DST,
    ST_PRE_FIN,
    ST_W_PRE_FIN,
    ST_DONE,
    ST_FAULT
  } rcs_state_e;

endpackage

// File: rtl/rcs_gap_timer.sv
module rcs_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // counter runs only while loaded or non-zero
  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)           cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // last wait cycle of the gap
  assign expire = (cnt_q == CNT_W'(1));

  // R3: a running gap never jumps; it shrinks by one per cycle
  a_r3_gap_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rcs_hop_path.sv
module rcs_hop_path #(
  parameter int SUB_W = 3
) (
  input  logic [SUB_W-1:0] cur_sub,
  input  logic [SUB_W-1:0] dst_sub,
  output logic [SUB_W-1:0] nxt_sub,
  output logic             last_hop
);

  logic step_up;

  assign step_up  = (dst_sub > cur_sub);
  assign nxt_sub  = step_up ? (cur_sub + 1'b1) : (cur_sub - 1'b1);
  assign last_hop = (nxt_sub == dst_sub);

endmodule

// File: rtl/rcs_cmd_drive.sv
module rcs_cmd_drive
  import rcs_pkg::*;
#(
  parameter int SUB_W = 3,
  parameter int ROW_W = 9
) (
  input  rcs_state_e       state,
  input  logic [SUB_W-1:0] cur_sub,
  input  logic [SUB_W-1:0] nxt_sub,
  input  logic [ROW_W-1:0] src_row,
  input  logic [SUB_W-1:0] end_sub,
  input  logic [ROW_W-1:0] end_row,
  output logic [1:0]       cmd_op,
  output logic [SUB_W-1:0] cmd_sub,
  output logic [SUB_W-1:0] cmd_tgt,
  output logic [ROW_W-1:0] cmd_row
);

  always_comb begin
    cmd_op  = OP_NOP;
    cmd_sub = '0;
    cmd_tgt = '0;
    cmd_row = '0;
    unique case (state)
      ST_ACT_SRC: begin
        cmd_op  = OP_ACT;
        cmd_sub = cur_sub;
        cmd_row = src_row;
      end
      ST_MOVE: begin
        cmd_op  = OP_RBM;
        cmd_sub = cur_sub;
        cmd_tgt = nxt_sub;
      end
      ST_PRE_HOP: begin
        cmd_op  = OP_PRE;
        cmd_sub = cur_sub;
      end
      ST_ACT_DST: begin
        cmd_op  = OP_ACT;
        cmd_sub = end_sub;
        cmd_row = end_row;
      end
      ST_PRE_FIN: begin
        cmd_op  = OP_PRE;
        cmd_sub = end_sub;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rowcopy_seq.sv
module rowcopy_seq
  import rcs_pkg::*;
#(
  parameter int N_SUB        = 8,
  parameter int ROWS_PER_SUB = 512,
  parameter int T_RCD        = 6,
  parameter int T_RP         = 6,
  parameter int T_RBM        = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_copy,
  input  logic [$clog2(N_SUB)-1:0]        req_src_sub,
  input  logic [$clog2(ROWS_PER_SUB)-1:0] req_src_row,
  input  logic [$clog2(N_SUB)-1:0]        req_dst_sub,
  input  logic [$clog2(ROWS_PER_SUB)-1:0] req_dst_row,
  output logic                            busy,
  output logic                            done,
  output logic                            err,
  output logic [1:0]                      cmd_op,
  output logic [$clog2(N_SUB)-1:0]        cmd_sub,
  output logic [$clog2(N_SUB)-1:0]        cmd_tgt,
  output logic [$clog2(ROWS_PER_SUB)-1:0] cmd_row
);

  localparam int SUB_W   = $clog2(N_SUB);
  localparam int ROW_W   = $clog2(ROWS_PER_SUB);
  localparam int GAP_A   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int GAP_MAX = (GAP_A > T_RBM) ? GAP_A : T_RBM;
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RBM = CNT_W'(T_RBM - 1);

  rcs_state_e       state_q, state_d;
  logic             is_copy_q;
  logic [ROW_W-1:0] src_row_q;
  logic [SUB_W-1:0] end_sub_q;
  logic [ROW_W-1:0] end_row_q;
  logic [SUB_W-1:0] cur_sub_q;

  logic             cap_en;
  logic             hop_en;
  logic             same_sub;
  logic [SUB_W-1:0] nxt_sub;
  logic             last_hop;
  logic             gap_load;
  logic [CNT_W-1:0] gap_val;
  logic             gap_exp;

  // ---------------- request capture ----------------
  assign cap_en   = (state_q == ST_IDLE) && req_valid;
  assign hop_en   = (state_q == ST_PRE_HOP);
  assign same_sub = (req_src_sub == req_dst_sub);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_copy_q <= 1'b0;
      src_row_q <= '0;
      end_sub_q <= '0;
      end_row_q <= '0;
    end else if (cap_en) begin
      is_copy_q <= req_copy;
      src_row_q <= req_src_row;
      end_sub_q <= req_copy ? req_dst_sub : req_src_sub;
      end_row_q <= req_copy ? req_dst_row : req_src_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_sub_q <= '0;
    else if (cap_en) cur_sub_q <= req_src_sub;
    else if (hop_en) cur_sub_q <= nxt_sub;
  end

  // ---------------- hop path ----------------
  rcs_hop_path #(.SUB_W(SUB_W)) u_path (
    .cur_sub  (cur_sub_q),
    .dst_sub  (end_sub_q),
    .nxt_sub  (nxt_sub),
    .last_hop (last_hop)
  );

  // ---------------- gap timer ----------------
  always_comb begin
    gap_load = 1'b0;
    gap_val  = LD_RCD;
    unique case (state_q)
      ST_ACT_SRC, ST_ACT_DST: begin gap_load = 1'b1; gap_val = LD_RCD; end
      ST_MOVE:                begin gap_load = 1'b1; gap_val = LD_RBM; end
      ST_PRE_FIN:             begin gap_load = 1'b1; gap_val = LD_RP;  end
      default: ;
    endcase
  end

  rcs_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .expire   (gap_exp)
  );

  // ---------------- sequencing ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_valid) state_d = (req_copy && same_sub) ? ST_FAULT : ST_ACT_SRC;
      ST_ACT_SRC:   state_d = ST_W_ACT_SRC;
      ST_W_ACT_SRC: if (gap_exp) state_d = is_copy_q ? ST_MOVE : ST_PRE_FIN;
      ST_MOVE:      state_d = ST_W_MOVE;
      ST_W_MOVE:    if (gap_exp) state_d = ST_PRE_HOP;
      ST_PRE_HOP:   state_d = last_hop ? ST_ACT_DST : ST_MOVE;
      ST_ACT_DST:   state_d = ST_W_ACT_DST;
      ST_W_ACT_DST: if (gap_exp) state_d = ST_PRE_FIN;
      ST_PRE_FIN:   state_d = ST_W_PRE_FIN;
      ST_W_PRE_FIN: if (gap_exp) state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      ST_FAULT:     state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign err  = (state_q == ST_FAULT);

  // ---------------- command drive ----------------
  rcs_cmd_drive #(.SUB_W(SUB_W), .ROW_W(ROW_W)) u_drive (
    .state   (state_q),
    .cur_sub (cur_sub_q),
    .nxt_sub (nxt_sub),
    .src_row (src_row_q),
    .end_sub (end_sub_q),
    .end_row (end_row_q),
    .cmd_op  (cmd_op),
    .cmd_sub (cmd_sub),
    .cmd_tgt (cmd_tgt),
    .cmd_row (cmd_row)
  );

  // ---------------- assertions ----------------
  logic [SUB_W:0] tgt_x, sub_x;
  assign tgt_x = {1'b0, cmd_tgt};
  assign sub_x = {1'b0, cmd_sub};

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd_op == OP_NOP && !done && !err));

  a_r4_hop_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_RBM) |-> (tgt_x == sub_x + 1'b1 || sub_x == tgt_x + 1'b1));

  a_r5_dst_after_hop_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACT_DST) |-> ($past(cmd_op) == OP_PRE));

  a_r6_done_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r6_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r7_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && cmd_op == OP_NOP));

  a_r8_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: tb/rowcopy_seq_tb_top.sv
module rowcopy_seq_tb_top;

  localparam int NS   = 8;
  localparam int NR   = 512;
  localparam int TRCD = 6;
  localparam int TRP  = 6;
  localparam int TRBM = 4;
  localparam int SW   = $clog2(NS);
  localparam int RW   = $clog2(NR);

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_copy;
  logic [SW-1:0] req_src_sub, req_dst_sub;
  logic [RW-1:0] req_src_row, req_dst_row;
  logic busy, done, err;
  logic [1:0] cmd_op;
  logic [SW-1:0] cmd_sub, cmd_tgt;
  logic [RW-1:0] cmd_row;

  always #2 clk = ~clk;

  rowcopy_seq #(.N_SUB(NS), .ROWS_PER_SUB(NR), .T_RCD(TRCD), .T_RP(TRP), .T_RBM(TRBM)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_copy(req_copy),
    .req_src_sub(req_src_sub), .req_src_row(req_src_row),
    .req_dst_sub(req_dst_sub), .req_dst_row(req_dst_row),
    .busy(busy), .done(done), .err(err),
    .cmd_op(cmd_op), .cmd_sub(cmd_sub), .cmd_tgt(cmd_tgt), .cmd_row(cmd_row));

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit finished = 1'b0;
  bit model_idle = 1'b1;

  typedef struct {
    int op; int sub; int tgt; int row;
    bit bz; bit dn; bit er;
  } exp_t;

  exp_t  eq[$];
  string tq[$];

  // behavioural bank: open flag and row-buffer tag per subarray, written rows
  bit bank_open[NS];
  int buf_tag[NS];
  int wr_tag[int];

  task automatic push(int op, int sub, int tgt, int row, bit bz, bit dn, bit er, string t);
    exp_t e;
    e.op = op; e.sub = sub; e.tgt = tgt; e.row = row; e.bz = bz; e.dn = dn; e.er = er;
    eq.push_back(e);
    tq.push_back(t);
  endtask

  task automatic pwait(int n, string t);
    for (int i = 0; i < n; i++) push(0, 0, 0, 0, 1'b1, 1'b0, 1'b0, t);
  endtask

  task automatic build(bit cp, int ss, int sr, int ds, int dr);
    int cur, nx;
    string ht;
    if (cp && ss == ds) begin
      push(0, 0, 0, 0, 1'b1, 1'b1, 1'b1, "R7");
    end else if (!cp) begin
      push(1, ss, 0, sr, 1'b1, 1'b0, 1'b0, "R2");
      pwait(TRCD - 1, "R2");
      push(2, ss, 0, 0, 1'b1, 1'b0, 1'b0, "R2");
      pwait(TRP - 1, "R2");
      push(0, 0, 0, 0, 1'b1, 1'b1, 1'b0, "R2");
    end else begin
      ht = (ds > ss) ? "R4" : "R9";
      push(1, ss, 0, sr, 1'b1, 1'b0, 1'b0, "R3");
      pwait(TRCD - 1, "R3");
      cur = ss;
      while (cur != ds) begin
        nx = (ds > cur) ? cur + 1 : cur - 1;
        push(3, cur, nx, 0, 1'b1, 1'b0, 1'b0, ht);
        pwait(TRBM - 1, ht);
        push(2, cur, 0, 0, 1'b1, 1'b0, 1'b0, ht);
        cur = nx;
      end
      push(1, ds, 0, dr, 1'b1, 1'b0, 1'b0, "R5");
      pwait(TRCD - 1, "R5");
      push(2, ds, 0, 0, 1'b1, 1'b0, 1'b0, "R5");
      pwait(TRP - 1, "R6");
      push(0, 0, 0, 0, 1'b1, 1'b1, 1'b0, "R6");
    end
  endtask

  task automatic fail_line(string t, string what, int act, int expv);
    n_bad++;
    $display("FAIL %s cycle %0d %s: actual=%0d expected=%0d", t, cyc, what, act, expv);
  endtask

  task automatic check_cycle();
    exp_t e;
    string t;
    bit ok;
    if (eq.size() == 0) begin
      e.op = 0; e.sub = 0; e.tgt = 0; e.row = 0; e.bz = 0; e.dn = 0; e.er = 0;
      t = "R1";
      model_idle = 1'b1;
    end else begin
      e = eq.pop_front();
      t = tq.pop_front();
      model_idle = 1'b0;
    end
    n_cmp++;
    ok = 1'b1;
    if (int'(cmd_op) != e.op) begin fail_line(t, "cmd_op", int'(cmd_op), e.op); ok = 0; end
    if (busy != e.bz && ok) begin fail_line(t, "busy", int'(busy), int'(e.bz)); ok = 0; end
    if (done != e.dn && ok) begin fail_line(t, "done", int'(done), int'(e.dn)); ok = 0; end
    if (err != e.er && ok) begin fail_line(t, "err", int'(err), int'(e.er)); ok = 0; end
    if (ok && e.op != 0 && int'(cmd_sub) != e.sub) begin fail_line(t, "cmd_sub", int'(cmd_sub), e.sub); ok = 0; end
    if (ok && e.op == 1 && int'(cmd_row) != e.row) begin fail_line(t, "cmd_row", int'(cmd_row), e.row); ok = 0; end
    if (ok && e.op == 3 && int'(cmd_tgt) != e.tgt) begin fail_line(t, "cmd_tgt", int'(cmd_tgt), e.tgt); ok = 0; end
    // bank model reacts to what the design actually drove
    case (int'(cmd_op))
      1: begin
        if (bank_open[cmd_sub]) wr_tag[int'(cmd_sub) * NR + int'(cmd_row)] = buf_tag[cmd_sub];
        else begin
          buf_tag[cmd_sub]   = int'(cmd_sub) * NR + int'(cmd_row);
          bank_open[cmd_sub] = 1'b1;
        end
      end
      2: bank_open[cmd_sub] = 1'b0;
      3: begin
        n_cmp++;
        if (!bank_open[cmd_sub] || bank_open[cmd_tgt])
          fail_line("R4", "move into open/from closed subarray", int'(bank_open[cmd_tgt]), 0);
        buf_tag[cmd_tgt]   = buf_tag[cmd_sub];
        bank_open[cmd_tgt] = 1'b1;
      end
      default: ;
    endcase
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    check_cycle();
  endtask

  task automatic req(bit cp, int ss, int sr, int ds, int dr);
    req_valid   = 1'b1;
    req_copy    = cp;
    req_src_sub = SW'(ss);
    req_src_row = RW'(sr);
    req_dst_sub = SW'(ds);
    req_dst_row = RW'(dr);
    if (model_idle) build(cp, ss, sr, ds, dr);
    step();
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (eq.size() != 0) step();
    step();
  endtask

  task automatic check_written(int ds, int dr, int ss, int sr, string t);
    int key;
    key = ds * NR + dr;
    n_cmp++;
    if (!wr_tag.exists(key)) fail_line(t, "destination row not written", -1, ss * NR + sr);
    else if (wr_tag[key] != ss * NR + sr) fail_line(t, "destination row content", wr_tag[key], ss * NR + sr);
  endtask

  task automatic check_unwritten(int ds, int dr, string t);
    n_cmp++;
    if (wr_tag.exists(ds * NR + dr)) fail_line(t, "ignored request wrote row", wr_tag[ds * NR + dr], -1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin bank_open[i] = 1'b0; buf_tag[i] = -1; end
    rst_n = 1'b0;
    req_valid = 1'b0; req_copy = 1'b0;
    req_src_sub = '0; req_dst_sub = '0; req_src_row = '0; req_dst_row = '0;
    // R1: outputs quiet during reset
    repeat (3) step();
    rst_n = 1'b1;
    repeat (2) step();

    // R2: single-row open/close
    req(1'b0, 3, 77, 0, 0);
    drain();

    // R3 R4 R5 R6: one-hop upward copy
    req(1'b1, 0, 10, 1, 20);
    drain();
    check_written(1, 20, 0, 10, "R3");

    // R4: three hops upward
    req(1'b1, 2, 300, 5, 511);
    drain();
    check_written(5, 511, 2, 300, "R3");

    // R9: full-span downward copy
    req(1'b1, 7, 1, 0, 255);
    drain();
    check_written(0, 255, 7, 1, "R9");

    // R7: same subarray refused, then back-to-back request
    req(1'b1, 4, 5, 4, 6);
    req(1'b0, 6, 400, 0, 0);
    drain();
    check_unwritten(4, 6, "R7");

    // R8: requests while busy, including the done cycle
    req(1'b1, 1, 42, 3, 43);
    repeat (4) step();
    req(1'b1, 6, 8, 7, 9);
    while (eq.size() > 1) step();
    req(1'b1, 5, 11, 4, 12);
    drain();
    check_written(3, 43, 1, 42, "R3");
    check_unwritten(7, 9, "R8");
    check_unwritten(4, 12, "R8");

    // R8: accepted right after idle returns
    req(1'b1, 4, 100, 2, 101);
    drain();
    check_written(2, 101, 4, 100, "R9");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R6 watchdog: actual=hung expected=completion");
      summary();
      $finish;
    end
  end

endmodule